// File: doc/BRIEF.md
# Windowed Capture Buffer Controller

This block stores a stream of data samples into an on-chip RAM, one sample on each rising clock edge, under the control of a trigger event and a storage-qualify strobe. Both come from detection logic outside the block. After an arm command it keeps the most recent samples in a ring while it waits for a trigger. It then completes the window around that trigger and moves on to the next window. When every window is full it disarms and raises a done flag. The stored samples and the per-window trigger addresses can then be read back.

Two capture modes exist. In window mode the RAM is divided into 2^k equal windows. A programmable position P leaves exactly P samples ahead of the trigger sample in each window. In count mode each window holds N samples (1 to depth minus 1), starting with the trigger sample. The windows are packed back to back until the next one would not fit or the window table is full. A force command starts a single full-depth window whose first sample is the trigger, without looking at the trigger or qualify inputs. A stop command disarms the block at any time.

To put a window back in time order, read it starting at the recorded trigger address minus P, wrapping inside the window.

Top module: `capbuf_ctrl`

## Requirements
- R1: After reset `busy` and `done` are 0.
- R2: In window mode with `cfg_win_log`=k and position P, window w covers addresses w*(64>>k) up to (w+1)*(64>>k)-1 at default depth 64. The trigger sample goes to the recorded address T. Reading the window from T-P, wrapping inside the window, gives P pre-trigger samples, the trigger sample and the following samples, all in capture order.
- R3: A trigger in window mode is accepted only once at least P samples of the current window have been stored. An earlier trigger is treated as an ordinary sample.
- R4: With more than one window, each window takes its own trigger, and entry w of the trigger table (`tab_sel`=w) holds that window's trigger address.
- R5: A trigger that arrives while the post-trigger part of a window is filling changes neither the stored data nor the recorded trigger address.
- R6: With `cfg_qual_en`=1, only cycles with `qual_in`=1 store a sample, both before and after the trigger. The trigger sample itself is always stored.
- R7: In count mode (`cfg_nsamp_mode`=1) window w starts at address w*N and its first sample is the trigger. Nothing is written before a trigger. Capture ends once the next window would pass the end of the RAM, or after 8 windows.
- R8: A `force_trig` pulse starts one full-depth window with the trigger at address 0. The trigger and qualify inputs are ignored, and so is the configuration.
- R9: A `stop` pulse clears `busy` on the next edge and does not set `done`. `stop` wins over `arm` and `force_trig`.
- R10: `rd_data` returns the word at `rd_addr` one clock edge after the address is presented.
- R11: The edge that stores the last sample of the last window clears `busy` and sets `done`. An arm or force command clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nsamp_mode | input | 1 | 1 selects count mode, 0 selects window mode |
| cfg_win_log | input | WLW | log2 of the number of windows in window mode |
| cfg_trig_pos | input | AW | Pre-trigger sample count P in window mode |
| cfg_nsamp | input | AW | Samples per window N in count mode |
| cfg_qual_en | input | 1 | Enables storage qualification |
| arm | input | 1 | Pulse: latch the configuration and start capture |
| force_trig | input | 1 | Pulse: start an immediate single-window capture |
| stop | input | 1 | Pulse: disarm |
| trig_in | input | 1 | Trigger event |
| qual_in | input | 1 | Storage-qualify strobe |
| din | input | DW | Sample data |
| busy | output | 1 | Capture in progress |
| done | output | 1 | All windows filled |
| rd_addr | input | AW | Read-back address |
| rd_data | output | DW | Read-back data, one edge of latency |
| tab_sel | input | 2^WLW-1 | Window index for the trigger table |
| tab_addr | output | AW | Recorded trigger address of the selected window |

## Verification
Several capture shapes are run, each with a counting data pattern so that every stored word shows which cycle it came from. A single large window with a trigger late enough to wrap the ring checks the time-order unroll. An early trigger that is ignored separates correct pre-trigger accounting from a design that fires at once. Two windows, with an extra trigger in the first window's post phase, separate per-window sequencing from triggers leaking between phases. A qualify strobe that is low on alternate cycles, with the trigger on a low cycle, shows that qualification applies everywhere except to the trigger sample. Count mode with a length that leaves a tail checks the packing and the stop rule. The tail must keep the words from the previous run. A forced capture run with every input disabled, plus a stop issued mid-capture, completes the set.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_PRE  = 2'd1,
    CAP_POST = 2'd2
  } cap_state_e;
endpackage

// File: rtl/capbuf_ram.sv
module capbuf_ram #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/capbuf_ttab.sv
module capbuf_ttab #(
  parameter int AW = 6,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [TW-1:0] widx,
  input  logic [AW-1:0] wdata,
  input  logic [TW-1:0] ridx,
  output logic [AW-1:0] rdata
);
  localparam int NWIN = 1 << TW;

  logic [AW-1:0] tab_q [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_ent
    logic hit;
    assign hit = we && (widx == TW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tab_q[g] <= '0;
      end else if (hit) begin
        tab_q[g] <= wdata;
      end
    end
  end

  assign rdata = tab_q[ridx];
endmodule

// File: rtl/capbuf_seq.sv
module capbuf_seq
  import capbuf_pkg::*;
#(
  parameter int AW  = 6,
  parameter int WLW = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_nmode,
  input  logic [WLW-1:0]              cfg_wl,
  input  logic [AW-1:0]               cfg_pos,
  input  logic [AW-1:0]               cfg_n,
  input  logic                        cfg_qen,
  input  logic                        arm,
  input  logic                        force_trig,
  input  logic                        stop,
  input  logic                        trig_in,
  input  logic                        qual_in,
  output logic                        busy,
  output logic                        done,
  output logic                        wr_en,
  output logic [AW-1:0]               wr_addr,
  output logic                        tab_we,
  output logic [(1<<WLW)-2:0]         tab_idx
);
  localparam int TW    = (1 << WLW) - 1;
  localparam int NWIN  = 1 << TW;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0]   ONES    = '1;
  localparam logic [AW+1:0]   DEPTH_W = (AW+2)'(DEPTH);
  localparam logic [TW-1:0]   TAB_END = TW'(NWIN - 1);

  cap_state_e     state_q, state_d;
  logic           nmode_q, nmode_d;
  logic [WLW-1:0] wl_q, wl_d;
  logic [AW-1:0]  pos_q, pos_d;
  logic [AW-1:0]  n_q, n_d;
  logic           qen_q, qen_d;
  logic           frc_q, frc_d;
  logic [AW:0]    base_q, base_d;
  logic [AW-1:0]  ptr_q, ptr_d;
  logic [AW-1:0]  prec_q, prec_d;
  logic [AW-1:0]  rem_q, rem_d;
  logic [TW-1:0]  win_q, win_d;
  logic           done_q, done_d;

  logic [AW-1:0]  wd_mask;
  logic [AW:0]    wsize;
  logic [AW-1:0]  post_len;
  logic [AW-1:0]  pos_eff;
  logic [AW-1:0]  ptr_inc;
  logic [AW+1:0]  nb;
  logic [AW+1:0]  nb_end;
  logic [TW-1:0]  win_last;
  logic           last_win;
  logic           qual_eff;
  logic           trig_eff;
  logic           win_end;

  // window geometry derived from the latched configuration
  always_comb begin
    wd_mask  = ONES >> wl_q;
    wsize    = nmode_q ? {1'b0, n_q} : ({1'b0, wd_mask} + 1'b1);
    post_len = nmode_q ? (n_q - 1'b1) : (wd_mask - pos_q);
    pos_eff  = nmode_q ? '0 : pos_q;
    ptr_inc  = nmode_q ? (ptr_q + 1'b1) : ((ptr_q + 1'b1) & wd_mask);
    nb       = {1'b0, base_q} + {1'b0, wsize};
    nb_end   = nb + {1'b0, wsize};
    win_last = ~({TW{1'b1}} << wl_q);
    if (nmode_q) begin
      last_win = (win_q == TAB_END) || (nb_end > DEPTH_W);
    end else begin
      last_win = (win_q == win_last);
    end
    qual_eff = frc_q | ~qen_q | qual_in;
    trig_eff = frc_q | trig_in;
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    nmode_d = nmode_q;
    wl_d    = wl_q;
    pos_d   = pos_q;
    n_d     = n_q;
    qen_d   = qen_q;
    frc_d   = frc_q;
    base_d  = base_q;
    ptr_d   = ptr_q;
    prec_d  = prec_q;
    rem_d   = rem_q;
    win_d   = win_q;
    done_d  = done_q;
    wr_en   = 1'b0;
    tab_we  = 1'b0;
    win_end = 1'b0;

    if (stop) begin
      state_d = CAP_IDLE;
    end else if (arm || force_trig) begin
      nmode_d = force_trig ? 1'b0 : cfg_nmode;
      wl_d    = force_trig ? '0   : cfg_wl;
      pos_d   = force_trig ? '0   : cfg_pos;
      n_d     = cfg_n;
      qen_d   = force_trig ? 1'b0 : cfg_qen;
      frc_d   = force_trig;
      base_d  = '0;
      ptr_d   = '0;
      prec_d  = '0;
      rem_d   = '0;
      win_d   = '0;
      done_d  = 1'b0;
      state_d = CAP_PRE;
    end else begin
      unique case (state_q)
        CAP_PRE: begin
          if (trig_eff && (prec_q >= pos_eff)) begin
            wr_en  = 1'b1;
            tab_we = 1'b1;
            if (post_len == '0) begin
              win_end = 1'b1;
            end else begin
              state_d = CAP_POST;
              rem_d   = post_len;
              ptr_d   = ptr_inc;
            end
          end else if (!nmode_q && qual_eff) begin
            wr_en = 1'b1;
            ptr_d = ptr_inc;
            if (prec_q < pos_q) begin
              prec_d = prec_q + 1'b1;
            end
          end
        end
        CAP_POST: begin
          if (qual_eff) begin
            wr_en = 1'b1;
            ptr_d = ptr_inc;
            rem_d = rem_q - 1'b1;
            if (rem_q == AW'(1)) begin
              win_end = 1'b1;
            end
          end
        end
        default: ;
      endcase

      if (win_end) begin
        if (last_win) begin
          state_d = CAP_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = CAP_PRE;
          base_d  = nb[AW:0];
          ptr_d   = '0;
          prec_d  = '0;
          win_d   = win_q + 1'b1;
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      nmode_q <= 1'b0;
      wl_q    <= '0;
      pos_q   <= '0;
      n_q     <= '0;
      qen_q   <= 1'b0;
      frc_q   <= 1'b0;
      base_q  <= '0;
      ptr_q   <= '0;
      prec_q  <= '0;
      rem_q   <= '0;
      win_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      nmode_q <= nmode_d;
      wl_q    <= wl_d;
      pos_q   <= pos_d;
      n_q     <= n_d;
      qen_q   <= qen_d;
      frc_q   <= frc_d;
      base_q  <= base_d;
      ptr_q   <= ptr_d;
      prec_q  <= prec_d;
      rem_q   <= rem_d;
      win_q   <= win_d;
      done_q  <= done_d;
    end
  end

  assign busy    = (state_q != CAP_IDLE);
  assign done    = done_q;
  assign wr_addr = base_q[AW-1:0] + ptr_q;
  assign tab_idx = win_q;
endmodule

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl #(
  parameter int DW  = 8,
  parameter int AW  = 6,
  parameter int WLW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_nsamp_mode,
  input  logic [WLW-1:0]        cfg_win_log,
  input  logic [AW-1:0]         cfg_trig_pos,
  input  logic [AW-1:0]         cfg_nsamp,
  input  logic                  cfg_qual_en,
  input  logic                  arm,
  input  logic                  force_trig,
  input  logic                  stop,
  input  logic                  trig_in,
  input  logic                  qual_in,
  input  logic [DW-1:0]         din,
  output logic                  busy,
  output logic                  done,
  input  logic [AW-1:0]         rd_addr,
  output logic [DW-1:0]         rd_data,
  input  logic [(1<<WLW)-2:0]   tab_sel,
  output logic [AW-1:0]         tab_addr
);
  localparam int TW = (1 << WLW) - 1;

  logic          rst_s0_q, rst_s1_q;
  logic          rst_int_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          tab_we;
  logic [TW-1:0] tab_idx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q <= 1'b0;
      rst_s1_q <= 1'b0;
    end else begin
      rst_s0_q <= 1'b1;
      rst_s1_q <= rst_s0_q;
    end
  end
  assign rst_int_n = rst_s1_q;

  capbuf_seq #(.AW(AW), .WLW(WLW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_nmode  (cfg_nsamp_mode),
    .cfg_wl     (cfg_win_log),
    .cfg_pos    (cfg_trig_pos),
    .cfg_n      (cfg_nsamp),
    .cfg_qen    (cfg_qual_en),
    .arm        (arm),
    .force_trig (force_trig),
    .stop       (stop),
    .trig_in    (trig_in),
    .qual_in    (qual_in),
    .busy       (busy),
    .done       (done),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .tab_we     (tab_we),
    .tab_idx    (tab_idx)
  );

  capbuf_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (din),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  capbuf_ttab #(.AW(AW), .TW(TW)) u_ttab (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (tab_we),
    .widx  (tab_idx),
    .wdata (wr_addr),
    .ridx  (tab_sel),
    .rdata (tab_addr)
  );
endmodule

// File: rtl/capbuf_ctrl_chk.sv
module capbuf_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic force_trig,
  input logic stop,
  input logic busy,
  input logic done,
  input logic wr_en
);
  assert_stop_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy);

  assert_start_clears_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm || force_trig) && !stop) |=> (busy && !done));

  assert_done_means_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_end_without_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(stop)) |-> done);

  assert_done_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_en));
endmodule

bind capbuf_ctrl capbuf_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arm        (arm),
  .force_trig (force_trig),
  .stop       (stop),
  .busy       (busy),
  .done       (done),
  .wr_en      (wr_en)
);

// File: tb/capbuf_ctrl_tb.sv
`timescale 1ns/1ps
module capbuf_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic       cfg_nsamp_mode;
  logic [1:0] cfg_win_log;
  logic [5:0] cfg_trig_pos;
  logic [5:0] cfg_nsamp;
  logic       cfg_qual_en;
  logic       arm, force_trig, stop, trig_in, qual_in;
  logic [7:0] din;
  logic       busy, done;
  logic [5:0] rd_addr;
  logic [7:0] rd_data;
  logic [2:0] tab_sel;
  logic [5:0] tab_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [5:0] a;
    logic [7:0] d;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  bit trig_pat [256];
  bit qual_pat [256];

  capbuf_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_nsamp_mode(cfg_nsamp_mode),
    .cfg_win_log(cfg_win_log), .cfg_trig_pos(cfg_trig_pos),
    .cfg_nsamp(cfg_nsamp), .cfg_qual_en(cfg_qual_en), .arm(arm),
    .force_trig(force_trig), .stop(stop), .trig_in(trig_in),
    .qual_in(qual_in), .din(din), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data), .tab_sel(tab_sel),
    .tab_addr(tab_addr)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int a, input int d, input string req);
    exp_t e;
    e.a = 6'(a);
    e.d = 8'(d);
    e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pops expected words and compares the read-back port (R10 latency)
  task automatic drain();
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      @(negedge clk);
      rd_addr = e.a;
      @(negedge clk);
      check(rd_data == e.d, e.req, $sformatf("word @%0d", e.a), rd_data, e.d);
    end
  endtask

  task automatic clear_pat();
    for (int i = 0; i < 256; i++) begin
      trig_pat[i] = 0;
      qual_pat[i] = 0;
    end
  endtask

  task automatic check_tab(input int idx, input int exp, input string req);
    @(negedge clk);
    tab_sel = 3'(idx);
    #1;
    check(tab_addr == 6'(exp), req, $sformatf("trigger addr win %0d", idx), tab_addr, exp);
  endtask

  // driver: feeds sample i = seed+i until done or max samples
  task automatic capture(input int seed, input int max, output int n);
    int i = 0;
    forever begin
      @(negedge clk);
      arm = 0;
      force_trig = 0;
      if (done || i >= max) break;
      din = 8'(seed + i);
      trig_in = trig_pat[i];
      qual_in = qual_pat[i];
      i++;
    end
    trig_in = 0;
    qual_in = 0;
    n = i;
  endtask

  task automatic start(input bit nm, input int wl, input int pos, input int ns,
                       input bit qen);
    @(negedge clk);
    cfg_nsamp_mode = nm;
    cfg_win_log = 2'(wl);
    cfg_trig_pos = 6'(pos);
    cfg_nsamp = 6'(ns);
    cfg_qual_en = qen;
    arm = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0;
    cfg_nsamp_mode = 0; cfg_win_log = 0; cfg_trig_pos = 0; cfg_nsamp = 1;
    cfg_qual_en = 0; arm = 0; force_trig = 0; stop = 0;
    trig_in = 0; qual_in = 0; din = 0; rd_addr = 0; tab_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(busy == 0, "R1", "busy after reset", busy, 0);
    check(done == 0, "R1", "done after reset", done, 0);

    // A: one window, P=5, early trigger at 2 ignored (R3), wrap (R2)
    clear_pat();
    trig_pat[2] = 1; trig_pat[20] = 1;
    start(0, 0, 5, 1, 0);
    capture(8'h10, 250, n);
    check(n == 79, "R11", "samples until done (A)", n, 79);
    check(done == 1 && busy == 0, "R11", "done/busy (A)", {done, busy}, 2);
    check_tab(0, 20, "R3");
    for (int k = 0; k < 64; k++) push((15 + k) % 64, 8'h10 + 15 + k, "R2");
    drain();

    // B: two windows, P=3, trigger in post phase ignored (R5)
    clear_pat();
    trig_pat[3] = 1; trig_pat[10] = 1; trig_pat[40] = 1;
    start(0, 1, 3, 1, 0);
    capture(8'h80, 250, n);
    check(n == 69, "R4", "samples until done (B)", n, 69);
    check_tab(0, 3, "R5");
    check_tab(1, 40, "R4");
    for (int k = 0; k < 32; k++) push(k, 8'h80 + k, "R5");
    for (int k = 0; k < 32; k++) push(32 + (5 + k) % 32, 8'h80 + 37 + k, "R4");
    drain();

    // C: qualification on even cycles, trigger on an odd cycle (R6)
    clear_pat();
    for (int i = 0; i < 256; i += 2) qual_pat[i] = 1;
    trig_pat[1] = 1; trig_pat[5] = 1; trig_pat[7] = 1;
    start(0, 0, 4, 1, 1);
    capture(8'h40, 250, n);
    check(n == 125, "R6", "samples until done (C)", n, 125);
    check_tab(0, 4, "R6");
    for (int k = 0; k < 4; k++) push(k, 8'h40 + 2 * k, "R6");
    push(4, 8'h40 + 7, "R6");
    for (int j = 0; j < 59; j++) push(5 + j, 8'h40 + 8 + 2 * j, "R6");
    drain();

    // D: count mode N=20, three windows, tail untouched (R7)
    clear_pat();
    trig_pat[5] = 1; trig_pat[10] = 1; trig_pat[30] = 1; trig_pat[50] = 1;
    start(1, 0, 0, 20, 0);
    capture(8'hC0, 250, n);
    check(n == 70, "R7", "samples until done (D)", n, 70);
    check_tab(0, 0, "R7");
    check_tab(1, 20, "R7");
    check_tab(2, 40, "R7");
    for (int k = 0; k < 20; k++) push(k, 8'hC0 + 5 + k, "R7");
    for (int k = 0; k < 20; k++) push(20 + k, 8'hC0 + 30 + k, "R7");
    for (int k = 0; k < 20; k++) push(40 + k, 8'hC0 + 50 + k, "R7");
    for (int a = 60; a < 64; a++) push(a, 8'h40 + 8 + 2 * (a - 5), "R7");
    drain();

    // E: forced capture ignores trig/qual and configuration (R8)
    clear_pat();
    @(negedge clk);
    cfg_nsamp_mode = 0; cfg_win_log = 2; cfg_trig_pos = 7; cfg_qual_en = 1;
    force_trig = 1;
    capture(8'h20, 250, n);
    check(n == 64, "R8", "samples until done (E)", n, 64);
    check_tab(0, 0, "R8");
    for (int k = 0; k < 64; k++) push(k, 8'h20 + k, "R8");
    drain();

    // R10: one edge of read latency
    @(negedge clk);
    rd_addr = 5;
    @(negedge clk);
    rd_addr = 6;
    #1;
    check(rd_data == 8'h25, "R10", "data before edge", rd_data, 8'h25);
    @(negedge clk);
    check(rd_data == 8'h26, "R10", "data after edge", rd_data, 8'h26);

    // F: stop mid-capture (R9)
    clear_pat();
    start(0, 0, 0, 1, 0);
    capture(8'h00, 10, n);
    check(busy == 1, "R9", "busy before stop", busy, 1);
    stop = 1;
    @(negedge clk);
    stop = 0;
    check(busy == 0, "R9", "busy after stop", busy, 0);
    check(done == 0, "R9", "done after stop", done, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule